// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block connects a simple synchronous host request port to an asynchronous 1M x 16 extended-data-out DRAM whose row and column addresses share ten pins. The host gives one access at a time: a 20-bit word address, write data, two byte enables and a read/write flag. The controller splits the address into a row half and a column half. It then drives the row strobe, the two per-byte column strobes, write enable and output enable. Every minimum interval is counted in whole clock cycles, and each count is derived at elaboration from nanosecond parameters and the clock period.

The controller also keeps the array refreshed. A free-running timer raises a refresh request often enough to fit 1024 refreshes into 16 ms. Each request is served as one column-strobe-before-row-strobe cycle. A pending refresh goes ahead of a waiting host access but never cuts into an access already started. The host raises `host_req` with stable request fields and holds it until `host_ready` pulses. All counts below assume the default 4 ns clock.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller holds `dram_ras_n`, `dram_ucas_n`, `dram_lcas_n`, `dram_we_n` and `dram_oe_n` high and `host_ready` and `dram_dq_oe` low.
- R2: For a host access, `dram_addr` carries host address bits 19:10 (the row) when `dram_ras_n` falls and bits 9:0 (the column) when the column strobes fall.
- R3: The row address is held on the pins for at least 2 cycles after `dram_ras_n` falls, and the column strobes fall no earlier than 3 cycles after `dram_ras_n` falls.
- R4: `host_be[1]` selects `dram_ucas_n` (data bits 15:8) and `host_be[0]` selects `dram_lcas_n` (bits 7:0); at least one enable is set. A write changes only the enabled bytes, and a read returns zero in each byte that is not enabled.
- R5: A write uses early-write timing. `dram_we_n` is low and `dram_dq_oe` is high in the cycle before the column strobes fall, and both stay that way while the strobes are low.
- R6: A read keeps `dram_we_n` high and drives `dram_oe_n` low while the column strobes are low. The data bus is sampled one cycle after a 4-cycle access count from the strobe fall, so it is sampled on the fifth rising edge after the strobes fall.
- R7: `dram_ras_n` stays low for at least 13 cycles and at most 2500 cycles, and stays high for at least 8 cycles before it falls again.
- R8: A refresh drives both column strobes low while `dram_ras_n` is high and `dram_we_n` is high, and lowers `dram_ras_n` only in a later cycle.
- R9: A refresh request is raised every 3900 cycles (15.6 us). It is served ahead of a waiting host request, even when host requests arrive back to back, and never interrupts an access in progress.
- R10: `host_ready` pulses high for exactly one cycle for each accepted access. On a read, `host_rdata` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address, row in bits 19:10 |
| host_be | input | 2 | Byte enables, bit 1 = upper byte |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, disabled bytes zero |
| dram_ras_n | output | 1 | Row address strobe |
| dram_ucas_n | output | 1 | Column strobe, upper byte |
| dram_lcas_n | output | 1 | Column strobe, lower byte |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The first pattern is a word write followed by a word read. It shows whether both byte lanes and the full address split reach the array. Single-byte writes and reads then separate the two strobe lanes: a crossed or merged lane corrupts the neighbouring byte or leaves a non-zero masked byte. Addresses with all-ones columns and all-ones rows catch a row/column swap. The bench model returns junk until the access time has run, so a read that samples too early is exposed. A long stream of back-to-back accesses placed across the refresh deadline tells a controller that gives refresh priority apart from one that lets the host starve it, and checks that the accesses around the refresh still complete intact.

// File: rtl/edo_ctl_pkg.sv
// Package for the EDO DRAM controller.
// Holds the sequencer state type and the elaboration-time helpers that
// turn nanosecond minimums into whole clock cycles.
package edo_ctl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // strobes idle, waiting for work
        ST_ROW,     // row address set up, RAS still high
        ST_RCD,     // RAS low, counting RAS-to-CAS delay
        ST_CAS,     // CAS low, counting access time
        ST_SAMPLE,  // CAS low, read data captured at the end
        ST_HOLD,    // CAS high, RAS low until pulse minimum met
        ST_PRE,     // RAS high, counting precharge
        ST_RCAS,    // refresh: CAS low ahead of RAS
        ST_RRAS     // refresh: RAS low with CAS low
    } edo_state_e;

    // Round a nanosecond minimum up to whole clock periods.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_step_counter.sv
// Saturating up-counter used for timing intervals.
// Assumes: clear restarts the count at zero in the next cycle; the count
// stops at its all-ones value instead of wrapping.
module edo_step_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [WIDTH-1:0] count
);

    // Count cycles since the last clear, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/edo_refresh_timer.sv
// Periodic refresh request generator.
// Raises pending once every INTERVAL_CYC cycles and holds it until the
// sequencer acknowledges. Assumes a new tick in the acknowledge cycle
// must not be lost, so a set wins over a clear.
module edo_refresh_timer #(
    parameter int INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == LAST);

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Pending flag: set on a tick, cleared when the refresh starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (tick) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/edo_dram_ctrl.sv
// EDO DRAM access controller (top).
// Runs one host access at a time over a multiplexed-address asynchronous
// DRAM with per-byte column strobes, using early-write timing, and inserts
// CAS-before-RAS refresh on a fixed schedule. Assumes the host keeps its
// request fields stable from host_req high until host_ready.
module edo_dram_ctrl
    import edo_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 4,
    parameter int ADDR_PINS      = 10,
    parameter int DATA_W         = 16,
    parameter int T_RC_NS        = 84,
    parameter int T_RP_NS        = 30,
    parameter int T_RAS_NS       = 50,
    parameter int T_RAS_MAX_NS   = 10000,
    parameter int T_RCD_NS       = 11,
    parameter int T_RAH_NS       = 7,
    parameter int T_CAS_NS       = 7,
    parameter int T_CAC_NS       = 13,
    parameter int T_CSR_NS       = 5,
    parameter int REFRESH_NS     = 15600
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_wr,
    input  logic [2*ADDR_PINS-1:0] host_addr,
    input  logic [1:0]             host_be,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ready,
    output logic [DATA_W-1:0]      host_rdata,
    output logic                   dram_ras_n,
    output logic                   dram_ucas_n,
    output logic                   dram_lcas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ADDR_PINS-1:0]   dram_addr,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);

    localparam int HALF        = DATA_W / 2;
    localparam int RAH_CYC     = ns_to_cycles(T_RAH_NS, CLK_PERIOD_NS);
    localparam int RCD_CYC     = imax(ns_to_cycles(T_RCD_NS, CLK_PERIOD_NS), RAH_CYC + 1);
    localparam int CAC_CYC     = imax(ns_to_cycles(T_CAC_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_CAS_NS, CLK_PERIOD_NS) - 1);
    localparam int RP_CYC      = ns_to_cycles(T_RP_NS, CLK_PERIOD_NS);
    localparam int RAS_LOW_CYC = imax(ns_to_cycles(T_RAS_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_RC_NS, CLK_PERIOD_NS) - RP_CYC);
    localparam int RAS_MAX_CYC = T_RAS_MAX_NS / CLK_PERIOD_NS;
    localparam int CSR_CYC     = imax(ns_to_cycles(T_CSR_NS, CLK_PERIOD_NS), 1);
    localparam int REF_CYC     = REFRESH_NS / CLK_PERIOD_NS;
    localparam int STEP_MAX    = imax(imax(RCD_CYC, CAC_CYC), imax(RP_CYC, CSR_CYC));
    localparam int CNT_W       = $clog2(STEP_MAX + 1);
    localparam int RAS_W       = $clog2(RAS_MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RAH_LIM  = CNT_W'(RAH_CYC);
    localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(RCD_CYC - 1);
    localparam logic [CNT_W-1:0] CAC_LAST = CNT_W'(CAC_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(RP_CYC - 1);
    localparam logic [CNT_W-1:0] CSR_LAST = CNT_W'(CSR_CYC - 1);
    localparam logic [RAS_W-1:0] RAS_LAST = RAS_W'(RAS_LOW_CYC - 1);
    localparam logic [RAS_W-1:0] RAS_CAP  = RAS_W'(RAS_MAX_CYC);
    localparam logic [RAS_W-1:0] RCD_MIN  = RAS_W'(RCD_CYC);

    edo_state_e state_q, state_d;
    logic [CNT_W-1:0]       step_cnt;
    logic [RAS_W-1:0]       ras_cnt;
    logic                   ref_pending, ref_ack, accept;
    logic [2*ADDR_PINS-1:0] addr_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [1:0]             be_q;
    logic                   wr_q;
    logic                   cas_phase, ref_cas, row_phase;

    edo_refresh_timer #(.INTERVAL_CYC(REF_CYC)) u_ref_timer (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pending)
    );

    edo_step_counter #(.WIDTH(CNT_W)) u_step_cnt (
        .clk(clk), .rst_n(rst_n), .clear(state_d != state_q), .count(step_cnt)
    );

    edo_step_counter #(.WIDTH(RAS_W)) u_ras_cnt (
        .clk(clk), .rst_n(rst_n), .clear(dram_ras_n), .count(ras_cnt)
    );

    assign ref_ack = (state_q == ST_IDLE) && ref_pending;
    assign accept  = (state_q == ST_IDLE) && !ref_pending && host_req;

    // Next-state selection for access and refresh sequences.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ref_pending) state_d = ST_RCAS;
                       else if (host_req) state_d = ST_ROW;
            ST_ROW:    state_d = ST_RCD;
            ST_RCD:    if (step_cnt == RCD_LAST) state_d = ST_CAS;
            ST_CAS:    if (step_cnt == CAC_LAST) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_HOLD;
            ST_HOLD:   if (ras_cnt >= RAS_LAST) state_d = ST_PRE;
            ST_PRE:    if (step_cnt == RP_LAST) state_d = ST_IDLE;
            ST_RCAS:   if (step_cnt == CSR_LAST) state_d = ST_RRAS;
            ST_RRAS:   if (ras_cnt >= RAS_LAST) state_d = ST_PRE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the host request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
            wr_q    <= host_wr;
        end
    end

    // Completion pulse and masked read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ready <= (state_q == ST_SAMPLE);
            if (state_q == ST_SAMPLE && !wr_q) begin
                host_rdata <= {be_q[1] ? dram_dq_in[DATA_W-1:HALF] : {HALF{1'b0}},
                               be_q[0] ? dram_dq_in[HALF-1:0]      : {HALF{1'b0}}};
            end
        end
    end

    // Strobe, enable and address pin decode from the current state.
    always_comb begin
        cas_phase   = (state_q == ST_CAS) || (state_q == ST_SAMPLE);
        ref_cas     = (state_q == ST_RCAS) || (state_q == ST_RRAS);
        row_phase   = (state_q == ST_ROW) || ((state_q == ST_RCD) && (step_cnt < RAH_LIM));
        dram_ras_n  = !((state_q == ST_RCD) || cas_phase ||
                        (state_q == ST_HOLD) || (state_q == ST_RRAS));
        dram_ucas_n = !((cas_phase && be_q[1]) || ref_cas);
        dram_lcas_n = !((cas_phase && be_q[0]) || ref_cas);
        dram_we_n   = !(wr_q && ((state_q == ST_ROW) || (state_q == ST_RCD) || cas_phase));
        dram_oe_n   = !(!wr_q && cas_phase);
        dram_dq_oe  = !dram_we_n;
        dram_dq_out = wdata_q;
        dram_addr   = row_phase ? addr_q[2*ADDR_PINS-1:ADDR_PINS] : addr_q[ADDR_PINS-1:0];
    end

    // R7
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (ras_cnt < RAS_CAP));

    // R3
    rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ucas_n & dram_lcas_n) && !dram_ras_n) |-> (ras_cnt >= RCD_MIN));

    // R3
    rah_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_ucas_n && dram_lcas_n) |=> $stable(dram_addr));

    // R5
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ucas_n & dram_lcas_n) && !dram_we_n) |-> $past(!dram_we_n && dram_dq_oe));

    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_lcas_n) |-> ($past(!dram_lcas_n && !dram_ucas_n) && dram_we_n));

    // R6
    read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_dq_oe));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

endmodule

// File: tb/edo_dram_ctrl_tb.sv
// Scoreboard bench for edo_dram_ctrl with a behavioural EDO DRAM model.
module edo_dram_ctrl_tb;

    localparam int RAH_C    = 2;
    localparam int RCD_C    = 3;
    localparam int CAC_C    = 4;
    localparam int RP_C     = 8;
    localparam int RASLOW_C = 13;
    localparam int RASMAX_C = 2500;
    localparam int REF_C    = 3900;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [19:0] host_addr = '0;
    logic [1:0]  host_be = 2'b11;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #2 clk = ~clk;

    edo_dram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    // ---------------- DRAM model ----------------
    logic [15:0] mem [int];
    logic [9:0]  m_row = '0;
    logic [15:0] m_word = '0;
    int          m_cnt = 0;
    logic        m_ras_p = 1'b1, m_uc_p = 1'b1, m_lc_p = 1'b1;

    assign dram_dq_in = (m_cnt > CAC_C && !dram_oe_n) ?
        {dram_ucas_n ? 8'hEE : m_word[15:8], dram_lcas_n ? 8'hEE : m_word[7:0]} : 16'hBAD0;

    always @(negedge clk) begin
        logic [19:0] key;
        logic [15:0] w;
        if (m_ras_p && !dram_ras_n && dram_ucas_n && dram_lcas_n) m_row <= dram_addr;
        if (!dram_ras_n && m_uc_p && m_lc_p && !(dram_ucas_n && dram_lcas_n)) begin
            key = {m_row, dram_addr};
            w = mem.exists(int'(key)) ? mem[int'(key)] : init_word(key);
            if (!dram_we_n) begin
                if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
                if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
                mem[int'(key)] = w;
            end
            m_word <= w;
        end
        m_cnt   <= (!dram_ucas_n || !dram_lcas_n) ? m_cnt + 1 : 0;
        m_ras_p <= dram_ras_n;
        m_uc_p  <= dram_ucas_n;
        m_lc_p  <= dram_lcas_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit rd; logic [1:0] be; logic [15:0] data; } exp_t;
    exp_t        exp_q[$];
    logic [15:0] shadow [int];
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = 2'b11;
    bit          cur_wr = 1'b0;
    int          ready_seen = 0;

    task automatic access(input bit wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] w;
        exp_t e;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
        if (wr) begin
            if (be[1]) w[15:8] = d[15:8];
            if (be[0]) w[7:0]  = d[7:0];
            shadow[int'(a)] = w;
            e = '{rd: 1'b0, be: be, data: 16'h0};
        end else begin
            e = '{rd: 1'b1, be: be, data: {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00}};
        end
        exp_q.push_back(e);
        @(negedge clk);
        cur_addr = a; cur_be = be; cur_wr = wr;
        host_req = 1'b1; host_wr = wr; host_addr = a; host_be = be; host_wdata = d;
        do @(negedge clk); while (!host_ready);
        host_req = 1'b0;
    endtask

    // Monitor: pops an expected item per completion pulse (R6, R4, R10).
    always @(negedge clk) begin
        if (rst_n && host_ready) begin
            exp_t e;
            ready_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected ready", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                if (e.rd) chk(host_rdata == e.data, (e.be == 2'b11) ? "R6 read data" : "R4 byte read",
                              {16'h0, host_rdata}, {16'h0, e.data});
            end
        end
    end

    // ---------------- pin timing checker ----------------
    logic p_ras = 1'b1, p_uc = 1'b1, p_lc = 1'b1, p_we = 1'b1, p_dqoe = 1'b0;
    int   low_cnt = 0, high_cnt = 100, last_ref = 0, ref_seen = 0;
    bit   in_access = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                if (p_uc && p_lc) begin
                    in_access = 1'b1;
                    chk(dram_addr == cur_addr[19:10], "R2 row address", 32'(dram_addr), 32'(cur_addr[19:10]));
                end else begin
                    in_access = 1'b0;
                    chk(!p_uc && !p_lc && !dram_ucas_n && !dram_lcas_n && dram_we_n,
                        "R8 refresh order", {p_uc, p_lc, dram_we_n}, 3'b001);
                    if (ref_seen > 0)
                        chk((cyc - last_ref) <= REF_C + 60 && (cyc - last_ref) >= REF_C - 60,
                            "R9 refresh spacing", 32'(cyc - last_ref), 32'(REF_C));
                    last_ref = cyc;
                    ref_seen++;
                end
                chk(high_cnt >= RP_C, "R7 precharge", 32'(high_cnt), 32'(RP_C));
                low_cnt = 1;
            end else if (!dram_ras_n) begin
                if (in_access && p_uc && p_lc && !(dram_ucas_n && dram_lcas_n)) begin
                    chk(dram_addr == cur_addr[9:0], "R2 column address", 32'(dram_addr), 32'(cur_addr[9:0]));
                    chk(low_cnt >= RCD_C, "R3 ras-to-cas", 32'(low_cnt), 32'(RCD_C));
                    chk({~dram_ucas_n, ~dram_lcas_n} == cur_be, "R4 lane strobes",
                        32'({~dram_ucas_n, ~dram_lcas_n}), 32'(cur_be));
                    if (cur_wr) chk(!p_we && p_dqoe && !dram_we_n && dram_dq_oe, "R5 early write",
                                    {p_we, dram_we_n}, 2'b00);
                    else chk(dram_we_n && !dram_oe_n, "R6 read enables", {dram_we_n, dram_oe_n}, 2'b10);
                end
                if (in_access && low_cnt < RAH_C)
                    chk(dram_addr == cur_addr[19:10], "R3 row hold", 32'(dram_addr), 32'(cur_addr[19:10]));
                if (in_access && !(dram_ucas_n && dram_lcas_n) && cur_wr)
                    chk(!dram_we_n && dram_dq_oe, "R5 write held", {dram_we_n, dram_dq_oe}, 2'b01);
                low_cnt++;
            end else if (!p_ras && dram_ras_n) begin
                chk(low_cnt >= RASLOW_C && low_cnt <= RASMAX_C, "R7 ras pulse", 32'(low_cnt), 32'(RASLOW_C));
                high_cnt = 1;
            end else begin
                high_cnt++;
            end
        end
        p_ras = dram_ras_n; p_uc = dram_ucas_n; p_lc = dram_lcas_n;
        p_we = dram_we_n; p_dqoe = dram_dq_oe;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        finish_run();
    end

    // Stimulus
    initial begin
        logic [19:0] lfsr;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n,
            "R1 strobes in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1F);
        chk(!host_ready && !dram_dq_oe, "R1 ready/oe in reset", {host_ready, dram_dq_oe}, 2'b00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        access(1'b1, 20'h12345, 2'b11, 16'hBEEF);   // R2 R5 word write
        access(1'b0, 20'h12345, 2'b11, 16'h0);      // R6 word read
        access(1'b1, 20'h12345, 2'b01, 16'h7711);   // R4 lower byte only
        access(1'b0, 20'h12345, 2'b11, 16'h0);      // R4 expect BE11
        access(1'b1, 20'h00400, 2'b10, 16'hA5C3);   // R4 upper byte only
        access(1'b0, 20'h00400, 2'b10, 16'h0);      // R4 masked read
        access(1'b0, 20'h00400, 2'b01, 16'h0);      // R4 untouched lower
        access(1'b1, 20'h003FF, 2'b11, 16'h0F0F);   // R2 column all ones
        access(1'b1, 20'hFFC00, 2'b11, 16'hF0F0);   // R2 row all ones
        access(1'b0, 20'h003FF, 2'b11, 16'h0);
        access(1'b0, 20'hFFC00, 2'b11, 16'h0);
        access(1'b0, 20'hFFFFF, 2'b11, 16'h0);      // never written

        // R9: back-to-back stream across the refresh deadlines
        while (cyc < 3600) @(negedge clk);
        lfsr = 20'h5B1C3;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
            access(lfsr[0], {lfsr[19:12], 12'h0A5} ^ {4'h0, lfsr[15:0]}, (lfsr[3:2] == 2'b00) ? 2'b11 : lfsr[3:2],
                   lfsr[15:0] ^ 16'h3C3C);
        end
        while (cyc < 12400) @(negedge clk);
        chk(ref_seen >= 3, "R9 refresh count", 32'(ref_seen), 32'd3);
        chk(exp_q.size() == 0 && ready_seen == 132, "R10 one ready per access",
            32'(ready_seen), 32'd132);
        finish_run();
    end

endmodule